// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Decoder

A display panel reports its refresh position on one tearing-effect wire. That wire carries both a per-line pulse and a per-frame pulse. This block tells the two apart only by how long each pulse lasts. It then produces a one-cycle transfer trigger. The frame-update engine uses that trigger to start writing a new frame without visible tearing.

The input is first brought into the clock domain. Two width counters then measure every run of the wire at each of the two programmed active levels. When a run ends, its length is compared with a vertical threshold and a horizontal threshold. In frame mode the trigger follows the first vertical sync after arming. In line mode a line counter clears on each vertical sync and counts horizontal syncs, and the trigger fires when the count reaches a programmed line number. In internal mode a start request triggers at once. Every configuration input is static, and a width set that cannot be decoded is flagged and blocks tearing-based triggers.

Top module: `te_sync_decoder`

## Requirements
- R1: After synchronous reset `trig`, `armed`, `hs_det` and `vs_det` are low and `line_cnt` is 0.
- R2: In internal mode (`cfg_mode` 0, and the reserved value 3), a `start` sampled at an edge gives `trig` high for exactly the next cycle, and `armed` stays low.
- R3: `te_in` passes through SYNC_STAGES flops. A polarity bit of 1 makes that sync active-high and 0 makes it active-low. `cfg_vs_pol` and `cfg_hs_pol` are independent.
- R4: An active run whose length in cycles is at least `cfg_vs_width` produces a one-cycle `vs_det` one cycle after the run ends.
- R5: An active run that is at least `cfg_hs_width` but shorter than `cfg_vs_width` produces a one-cycle `hs_det`. A run shorter than `cfg_hs_width` is a glitch and produces nothing. `hs_det` and `vs_det` are never high together.
- R6: In frame mode (`cfg_mode` 1), `start` sets `armed`. The next `vs_det` comes with `trig`, and horizontal syncs never trigger.
- R7: In line mode (`cfg_mode` 2), `line_cnt` clears on each vertical sync and counts horizontal syncs, saturating at 2^LINE_W-1. `trig` fires on the horizontal sync that brings the count to `cfg_line`. When `cfg_line` is 0, it fires on the vertical sync itself.
- R8: `trig` fires at most once per arming. `armed` clears with the trigger, and later syncs do not trigger until a new `start`.
- R9: A `start` sampled in the same cycle as a firing sync still lets `trig` fire, and `armed` stays set. A `start` that arrives while the block is unarmed, together with a sync, only arms it.
- R10: `cfg_bad` is high when `cfg_hs_width` < 2, or `cfg_hs_width` equals `cfg_vs_width`, or `cfg_vs_width` is below 4 in frame mode or below 2 in any other mode. While `cfg_bad` is high, frame and line modes never assert `trig`, and `armed` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| te_in | input | 1 | Raw tearing-effect wire from the panel |
| cfg_mode | input | 2 | 0 internal, 1 frame, 2 line, 3 reserved (acts as internal) |
| cfg_hs_pol | input | 1 | Horizontal sync active level (1 = high) |
| cfg_vs_pol | input | 1 | Vertical sync active level (1 = high) |
| cfg_hs_width | input | W | Minimum horizontal sync width in cycles |
| cfg_vs_width | input | W | Minimum vertical sync width in cycles |
| cfg_line | input | LINE_W | Target line for line mode |
| start | input | 1 | Transfer request pulse |
| trig | output | 1 | One-cycle transfer trigger |
| armed | output | 1 | Waiting for a tearing-effect trigger |
| hs_det | output | 1 | Horizontal sync detected (one cycle) |
| vs_det | output | 1 | Vertical sync detected (one cycle) |
| line_cnt | output | LINE_W | Horizontal syncs since the last vertical sync |
| cfg_bad | output | 1 | Width configuration cannot be decoded |

## Verification
The critical overlap is a `start` request that lands in the same cycle as a sync that satisfies the trigger condition. The bench provokes it by releasing a vertical pulse and raising `start` exactly two cycles later, in the cycle where the run end is being decoded. This is done once with the block already armed and once with it unarmed. A scoreboard checks the result: the armed case must produce `vs_det` with `trig` and leave `armed` high, proven by a second trigger on the next frame without a new request. The unarmed case must produce `vs_det` alone, followed by a trigger on the next frame.

// File: rtl/te_pkg.sv
package te_pkg;

    typedef enum logic [1:0] {
        TRIG_INTERNAL = 2'd0,
        TRIG_FRAME    = 2'd1,
        TRIG_LINE     = 2'd2,
        TRIG_RSVD     = 2'd3
    } trig_mode_e;

    localparam int unsigned MIN_HS_WIDTH       = 2;
    localparam int unsigned MIN_VS_WIDTH_FRAME = 4;
    localparam int unsigned MIN_VS_WIDTH_OTHER = 2;

    // Sync event pair produced by the width classifier.
    typedef struct packed {
        logic vs;
        logic hs;
    } sync_ev_t;

    function automatic logic mode_waits_te(trig_mode_e m);
        return (m == TRIG_FRAME) || (m == TRIG_LINE);
    endfunction

    function automatic logic widths_illegal(int unsigned hs_w, int unsigned vs_w,
                                            trig_mode_e m);
        int unsigned vs_min;
        vs_min = (m == TRIG_FRAME) ? MIN_VS_WIDTH_FRAME : MIN_VS_WIDTH_OTHER;
        return (hs_w < MIN_HS_WIDTH) || (vs_w < vs_min) || (hs_w == vs_w);
    endfunction

endpackage

// File: rtl/te_sync_in.sv
module te_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain <= din;
        end else begin : g_multi
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], din};
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/te_run_meas.sv
module te_run_meas #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lvl,
    input  logic         act_high,
    output logic         run_end,
    output logic [W-1:0] run_len
);
    localparam logic [W-1:0] LEN_MAX = {W{1'b1}};

    logic         active;
    logic [W-1:0] cnt;

    assign active = (lvl == act_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (active) begin
            if (cnt != LEN_MAX) cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    // The run just finished: level left the active state with a run on record.
    assign run_end = !active && (cnt != '0);
    assign run_len = cnt;
endmodule

// File: rtl/te_trig_ctl.sv
module te_trig_ctl
    import te_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  trig_mode_e        mode,
    input  logic [LINE_W-1:0] line_tgt,
    input  logic              start,
    input  logic              blocked,
    input  sync_ev_t          ev,
    output logic              trig,
    output logic              armed,
    output logic              hs_det,
    output logic              vs_det,
    output logic [LINE_W-1:0] line_cnt
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic              waits;
    logic [LINE_W:0]   line_inc;
    logic [LINE_W-1:0] line_nxt;
    logic              line_hit;
    logic              fire_te;
    logic              fire_int;
    logic              armed_nxt;

    always_comb begin
        waits    = mode_waits_te(mode);
        line_inc = {1'b0, line_cnt} + 1'b1;

        line_nxt = line_cnt;
        if (mode == TRIG_LINE) begin
            if (ev.vs)
                line_nxt = '0;
            else if (ev.hs && line_cnt != LINE_MAX)
                line_nxt = line_inc[LINE_W-1:0];
        end else begin
            line_nxt = '0;
        end

        line_hit = (mode == TRIG_LINE) &&
                   ((ev.vs && line_tgt == '0) ||
                    (ev.hs && !ev.vs && line_inc == {1'b0, line_tgt}));

        fire_te  = armed && !blocked &&
                   (((mode == TRIG_FRAME) && ev.vs) || line_hit);
        fire_int = start && !waits;

        if (start && waits)
            armed_nxt = 1'b1;
        else if (fire_te)
            armed_nxt = 1'b0;
        else
            armed_nxt = armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig     <= 1'b0;
            armed    <= 1'b0;
            hs_det   <= 1'b0;
            vs_det   <= 1'b0;
            line_cnt <= '0;
        end else begin
            trig     <= fire_te || fire_int;
            armed    <= armed_nxt;
            hs_det   <= ev.hs;
            vs_det   <= ev.vs;
            line_cnt <= line_nxt;
        end
    end
endmodule

// File: rtl/te_sync_decoder.sv
module te_sync_decoder
    import te_pkg::*;
#(
    parameter int W           = 8,
    parameter int LINE_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              te_in,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_hs_pol,
    input  logic              cfg_vs_pol,
    input  logic [W-1:0]      cfg_hs_width,
    input  logic [W-1:0]      cfg_vs_width,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic              start,
    output logic              trig,
    output logic              armed,
    output logic              hs_det,
    output logic              vs_det,
    output logic [LINE_W-1:0] line_cnt,
    output logic              cfg_bad
);
    localparam int N_MEAS = 2;   // index 0: vertical level, 1: horizontal level

    trig_mode_e        mode;
    logic              te_s;
    logic [N_MEAS-1:0] meas_pol;
    logic [N_MEAS-1:0] meas_end;
    logic [W-1:0]      meas_len [N_MEAS];
    logic              same_pol;
    sync_ev_t          ev;

    assign mode     = trig_mode_e'(cfg_mode);
    assign meas_pol = {cfg_hs_pol, cfg_vs_pol};
    assign same_pol = (cfg_hs_pol == cfg_vs_pol);
    assign cfg_bad  = widths_illegal(int'(cfg_hs_width), int'(cfg_vs_width), mode);

    te_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (te_in),
        .dout (te_s)
    );

    generate
        for (genvar g = 0; g < N_MEAS; g++) begin : g_meas
            te_run_meas #(.W(W)) u_meas (
                .clk      (clk),
                .rst      (rst),
                .lvl      (te_s),
                .act_high (meas_pol[g]),
                .run_end  (meas_end[g]),
                .run_len  (meas_len[g])
            );
        end
    endgenerate

    // Width classifier: long runs are vertical, mid-length runs horizontal.
    always_comb begin
        ev.vs = meas_end[0] && (meas_len[0] >= cfg_vs_width);
        ev.hs = meas_end[1] && (meas_len[1] >= cfg_hs_width) &&
                !(same_pol && (meas_len[1] >= cfg_vs_width));
    end

    te_trig_ctl #(.LINE_W(LINE_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .line_tgt (cfg_line),
        .start    (start),
        .blocked  (cfg_bad),
        .ev       (ev),
        .trig     (trig),
        .armed    (armed),
        .hs_det   (hs_det),
        .vs_det   (vs_det),
        .line_cnt (line_cnt)
    );
endmodule

// File: rtl/te_sync_decoder_chk.sv
module te_sync_decoder_chk #(
    parameter int W      = 8,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cfg_mode,
    input logic              start,
    input logic              trig,
    input logic              armed,
    input logic              hs_det,
    input logic              vs_det,
    input logic [LINE_W-1:0] line_cnt,
    input logic              cfg_bad
);
    logic waiting_mode;
    assign waiting_mode = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!trig && !armed && !hs_det && !vs_det && line_cnt == '0));

    a_r2_internal_immediate: assert property (@(posedge clk) disable iff (rst)
        (start && !waiting_mode) |=> (trig && !armed));

    a_r4_vs_single_cycle: assert property (@(posedge clk) disable iff (rst)
        vs_det |=> !vs_det);

    a_r5_exclusive_class: assert property (@(posedge clk) disable iff (rst)
        hs_det |-> !vs_det);

    a_r6_frame_trig_on_vs: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd1 && trig) |-> vs_det);

    a_r7_line_clear_on_vs: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd2 && vs_det) |-> (line_cnt == '0));

    a_r8_disarm_on_trig: assert property (@(posedge clk) disable iff (rst)
        (trig && !$past(start)) |-> !armed);

    a_r8_trig_needs_cause: assert property (@(posedge clk) disable iff (rst)
        trig |-> ($past(armed) || $past(start)));

    a_r9_start_arms: assert property (@(posedge clk) disable iff (rst)
        (start && waiting_mode) |=> armed);

    a_r10_bad_blocks: assert property (@(posedge clk) disable iff (rst)
        (cfg_bad && waiting_mode) |-> !trig);
endmodule

bind te_sync_decoder te_sync_decoder_chk #(.W(W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/tb_te_sync_decoder.sv
`timescale 1ns/1ps
module tb_te_sync_decoder;
    localparam int W      = 8;
    localparam int LINE_W = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              te_in = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic              cfg_hs_pol = 1'b1;
    logic              cfg_vs_pol = 1'b1;
    logic [W-1:0]      cfg_hs_width = 8'd3;
    logic [W-1:0]      cfg_vs_width = 8'd10;
    logic [LINE_W-1:0] cfg_line = '0;
    logic              start = 1'b0;
    logic              trig, armed, hs_det, vs_det, cfg_bad;
    logic [LINE_W-1:0] line_cnt;

    te_sync_decoder #(.W(W), .LINE_W(LINE_W), .SYNC_STAGES(2)) dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        byte   kind;   // "V", "H" or "T"
        string req;
    } exp_t;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    bit   idle   = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(byte k, string req);
        exp_t e;
        e.kind = k;
        e.req  = req;
        sb.push_back(e);
    endtask

    // Monitor: compare each produced pulse with the scoreboard head.
    task automatic observe(byte k);
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected pulse actual=%0d expected=%0d", k, 0);
        end else begin
            e = sb.pop_front();
            if (e.kind != k) begin
                n_fail++;
                $display("FAIL %s actual=%0d expected=%0d", e.req, k, e.kind);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (vs_det) observe("V");
            if (hs_det) observe("H");
            if (trig)   observe("T");
        end
    end

    task automatic te_pulse(int w, int gap);
        @(negedge clk) te_in = !idle;
        repeat (w) @(negedge clk);
        te_in = idle;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain(string req);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, req, sb.size(), 0);
        sb.delete();
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        te_in = idle;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Vertical pulse with start raised in the cycle its end is decoded.
    task automatic vs_with_start(int w);
        @(negedge clk) te_in = !idle;
        repeat (w) @(negedge clk);
        te_in = idle;
        @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(!trig && !armed && !hs_det && !vs_det, "R1 outputs low", trig, 0);
        check(line_cnt == 0, "R1 line_cnt", line_cnt, 0);
        check(cfg_bad == 1'b0, "R10 legal widths", cfg_bad, 0);

        // R2: internal mode triggers the cycle after start
        cfg_mode = 2'd0;
        expect_ev("T", "R2 internal trig");
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(trig == 1'b1, "R2 trig next cycle", trig, 1);
        check(armed == 1'b0, "R2 not armed", armed, 0);
        @(negedge clk);
        check(trig == 1'b0, "R2 trig one cycle", trig, 0);
        cfg_mode = 2'd3;
        expect_ev("T", "R2 reserved mode trig");
        pulse_start();
        drain("R2 scoreboard");

        // R5/R4: classification, mode 1, unarmed
        cfg_mode = 2'd1;
        do_reset();
        te_pulse(2, 8);                           // glitch
        drain("R5 glitch ignored");
        expect_ev("H", "R5 width at hs threshold");
        te_pulse(3, 8);
        expect_ev("H", "R5 width below vs threshold");
        te_pulse(9, 8);
        expect_ev("V", "R4 width at vs threshold");
        te_pulse(10, 8);
        expect_ev("V", "R4 long vertical");
        te_pulse(12, 8);
        drain("R4 R5 classification");

        // R6/R8: frame mode arming
        pulse_start();
        check(armed == 1'b1, "R6 armed after start", armed, 1);
        expect_ev("H", "R6 hs does not trigger");
        te_pulse(4, 8);
        check(armed == 1'b1, "R6 still armed after hs", armed, 1);
        expect_ev("V", "R6 vs");
        expect_ev("T", "R6 trig with vs");
        te_pulse(12, 8);
        check(armed == 1'b0, "R8 disarmed", armed, 0);
        expect_ev("V", "R8 no second trig");
        te_pulse(12, 8);
        drain("R6 R8 scoreboard");

        // R9: start collides with a firing vertical sync
        pulse_start();
        expect_ev("V", "R9 armed collision vs");
        expect_ev("T", "R9 armed collision trig");
        vs_with_start(12);
        check(armed == 1'b1, "R9 stays armed", armed, 1);
        expect_ev("V", "R9 rearmed vs");
        expect_ev("T", "R9 rearmed trig");
        te_pulse(12, 8);
        check(armed == 1'b0, "R9 disarmed after second", armed, 0);
        expect_ev("V", "R9 unarmed collision vs only");
        vs_with_start(12);
        check(armed == 1'b1, "R9 start arms", armed, 1);
        expect_ev("V", "R9 next frame vs");
        expect_ev("T", "R9 next frame trig");
        te_pulse(12, 8);
        drain("R9 scoreboard");

        // R7: line mode, target 3
        cfg_mode = 2'd2;
        cfg_line = 11'd3;
        do_reset();
        pulse_start();
        expect_ev("V", "R7 vs");
        te_pulse(12, 6);
        expect_ev("H", "R7 line 1");
        te_pulse(3, 6);
        expect_ev("H", "R7 line 2");
        te_pulse(3, 6);
        check(line_cnt == 2, "R7 count two", line_cnt, 2);
        expect_ev("H", "R7 line 3");
        expect_ev("T", "R7 trig at line 3");
        te_pulse(3, 6);
        expect_ev("H", "R7 line 4 no trig");
        te_pulse(3, 6);
        check(line_cnt == 4, "R7 count four", line_cnt, 4);
        expect_ev("V", "R7 clear vs");
        te_pulse(12, 6);
        check(line_cnt == 0, "R7 cleared on vs", line_cnt, 0);
        drain("R7 scoreboard");

        // R7: target line 0 fires on the vertical sync
        cfg_line = 11'd0;
        pulse_start();
        expect_ev("V", "R7 line0 vs");
        expect_ev("T", "R7 line0 trig");
        te_pulse(12, 6);
        drain("R7 line0 scoreboard");

        // R7: saturation and last line
        cfg_line = 11'd2047;
        pulse_start();
        expect_ev("V", "R7 sat vs");
        te_pulse(12, 6);
        for (int i = 1; i <= 2049; i++) begin
            expect_ev("H", "R7 sat hs");
            if (i == 2047) expect_ev("T", "R7 trig at last line");
            te_pulse(3, 3);
        end
        check(line_cnt == 2047, "R7 saturate", line_cnt, 2047);
        drain("R7 sat scoreboard");

        // R3: active-low polarity on both
        cfg_mode   = 2'd1;
        cfg_hs_pol = 1'b0;
        cfg_vs_pol = 1'b0;
        idle       = 1'b1;
        do_reset();
        drain("R3 no spurious after reset");
        pulse_start();
        expect_ev("H", "R3 low hs");
        te_pulse(4, 8);
        expect_ev("V", "R3 low vs");
        expect_ev("T", "R3 low trig");
        te_pulse(12, 8);
        drain("R3 scoreboard");

        // R10: illegal widths
        cfg_hs_pol   = 1'b1;
        cfg_vs_pol   = 1'b1;
        idle         = 1'b0;
        cfg_hs_width = 8'd5;
        cfg_vs_width = 8'd5;
        do_reset();
        check(cfg_bad == 1'b1, "R10 equal widths", cfg_bad, 1);
        pulse_start();
        expect_ev("V", "R10 vs without trig");
        te_pulse(12, 8);
        check(armed == 1'b1, "R10 armed held", armed, 1);
        drain("R10 scoreboard");
        cfg_hs_width = 8'd2;
        cfg_vs_width = 8'd3;
        #1;
        check(cfg_bad == 1'b1, "R10 vs below frame min", cfg_bad, 1);
        cfg_mode = 2'd2;
        #1;
        check(cfg_bad == 1'b0, "R10 vs legal in line mode", cfg_bad, 0);
        cfg_hs_width = 8'd1;
        #1;
        check(cfg_bad == 1'b1, "R10 hs below min", cfg_bad, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule